// File: doc/BRIEF.md
# Physical Register Readiness Scoreboard with Dependent Wakeup

This block sits between register rename and an issue queue of an out-of-order core. It holds one readiness bit for each physical register. When an instruction is dispatched as the producer of a destination register, that register's bit is cleared. When the producer completes, its destination tag is broadcast. The broadcast sets the bit again and marks the matching source as ready in every queue entry that is waiting on that register. Each queue entry holds a fixed number of source tags. An entry whose sources are all ready raises its issue-ready line, which the issue selector outside this block consumes.

An operand can become ready between rename and queue insertion. To catch this, the scoreboard is checked again at insertion, and a completion broadcast in the same cycle is included in that check. Tags at or above the physical register count name control or miscellaneous state. These tags are never tracked: they never enter the scoreboard and never make an entry wait. Squashing an entry removes all of its pending waits. The block also flags the case where a new producer is allocated to a register that still has live waiters.

Top module: `psb_wakeup`

## Requirements
- R1: After reset every physical register reads ready on `preg_ready`, no slot is busy, no slot is issue-ready and `reuse_err` is 0.
- R2: An allocation of a tracked tag (below NPREG) clears that register's bit, visible on `preg_ready` in the cycle after the allocation.
- R3: A completion of a tracked tag sets that register's bit in the cycle after. If an allocation and a completion of the same tag occur in one cycle, the allocation wins and the bit reads not-ready.
- R4: On insertion, each source is ready if its rename-ready flag is set or if its scoreboard bit reads ready; otherwise the source waits. An inserted entry with all sources ready shows `issue_ready` in the cycle after insertion.
- R5: Tags greater than or equal to NPREG are treated as ready on insertion. Allocating or completing such a tag leaves `preg_ready` unchanged.
- R6: A completion wakes the matching waiting source in every busy slot at once. An entry's `issue_ready` rises in the cycle after its last waiting source is woken, and it stays high until the slot is squashed or reloaded.
- R7: A completion and an insertion in the same cycle, where an inserted source carries the completing tag, leave that source ready.
- R8: An entry with one source still waiting keeps `issue_ready` low after its other source is woken.
- R9: A squashed slot reads not busy and not ready in the next cycle, and a later completion of a tag it was waiting on does not revive it. If a squash and an insertion target the same slot in one cycle, the insertion wins.
- R10: An allocation of a tracked tag that a busy, unsquashed, not-reloaded slot is still waiting on (and that is not completing in the same cycle) drives `reuse_err` high for exactly the next cycle. No such waiter means no error.
- R11: An allocation and an insertion in the same cycle, where an inserted source names the allocated tag, leave that source waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_valid | input | 1 | A producer is dispatched this cycle |
| alloc_preg | input | TAG_W | Destination tag of the dispatched producer |
| cmp_valid | input | 1 | A producer completes this cycle |
| cmp_preg | input | TAG_W | Destination tag of the completing producer |
| ins_valid | input | 1 | Load a consumer into a queue slot |
| ins_slot | input | SLOT_W | Slot index to load |
| ins_src | input | NSRC*TAG_W | Source tags; source s at bits s*TAG_W upward |
| ins_pre_rdy | input | NSRC | Per-source ready flag already known at rename (bit s for source s) |
| squash_mask | input | NENT | Slots to remove, bit i for slot i |
| issue_ready | output | NENT | Slot i is busy with all sources ready |
| slot_busy | output | NENT | Slot i holds a consumer |
| preg_ready | output | NPREG | Scoreboard bit per physical register, 1 = ready |
| reuse_err | output | 1 | Producer allocated over live waiters in the previous cycle |

## Verification
The bench builds the block with its defaults: 32 physical registers, 8 slots and 2 sources per slot. The tag width is therefore 6 bits, and tags 32 to 63 exercise the untracked path. Eight slots allow several entries to wait on one tag, so a single broadcast can be seen waking more than one of them. Two sources per slot allow the cases where a partial wakeup must not raise issue-ready. The same-cycle collisions are driven directly: allocation with completion, completion with insertion, allocation with insertion, and squash followed by a stale completion.

// File: rtl/psb_pkg.sv
package psb_pkg;
  localparam int DEF_NPREG = 32;
  localparam int DEF_NENT  = 8;
  localparam int DEF_NSRC  = 2;

  // one extra bit so that out-of-file tags can be named
  function automatic int tag_width(input int npreg);
    return $clog2(npreg) + 1;
  endfunction

  function automatic int slot_width(input int nent);
    return (nent > 1) ? $clog2(nent) : 1;
  endfunction
endpackage

// File: rtl/psb_sb_bits.sv
module psb_sb_bits #(
  parameter int NPREG = 32,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_v,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             cmp_v,
  input  logic [TAG_W-1:0] cmp_tag,
  output logic [NPREG-1:0] bits_q,
  output logic [NPREG-1:0] bits_nxt
);
  for (genvar i = 0; i < NPREG; i++) begin : g_bit
    logic set_hit, clr_hit;
    assign set_hit = cmp_v   && (cmp_tag   == TAG_W'(i));
    assign clr_hit = alloc_v && (alloc_tag == TAG_W'(i));
    // a new producer overrides a completion of the same register
    assign bits_nxt[i] = clr_hit ? 1'b0 : (set_hit ? 1'b1 : bits_q[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bits_q[i] <= 1'b1;
      else        bits_q[i] <= bits_nxt[i];
    end
  end
endmodule

// File: rtl/psb_insert_check.sv
module psb_insert_check #(
  parameter int NPREG = 32,
  parameter int NSRC  = 2,
  parameter int TAG_W = 6,
  localparam int IDX_W = TAG_W - 1
) (
  input  logic [NSRC*TAG_W-1:0] src_tags,
  input  logic [NSRC-1:0]       pre_rdy,
  input  logic [NPREG-1:0]      sb_view,
  output logic [NSRC-1:0]       src_rdy
);
  localparam logic [TAG_W-1:0] LIM = TAG_W'(NPREG);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [TAG_W-1:0] tag;
    logic             tracked;
    assign tag     = src_tags[s*TAG_W +: TAG_W];
    assign tracked = (tag < LIM);
    assign src_rdy[s] = pre_rdy[s] || !tracked || sb_view[tag[IDX_W-1:0]];
  end
endmodule

// File: rtl/psb_slot.sv
module psb_slot #(
  parameter int NPREG = 32,
  parameter int NSRC  = 2,
  parameter int TAG_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  kill,
  input  logic                  load,
  input  logic [NSRC*TAG_W-1:0] load_tags,
  input  logic [NSRC-1:0]       load_rdy,
  input  logic                  cmp_v,
  input  logic [TAG_W-1:0]      cmp_tag,
  output logic                  busy,
  output logic [NSRC-1:0]       waiting,
  output logic [NSRC*TAG_W-1:0] tags,
  output logic                  all_rdy
);
  localparam logic [TAG_W-1:0] LIM = TAG_W'(NPREG);

  logic [NSRC-1:0] rdy_q;
  logic [NSRC-1:0] wake_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy <= 1'b0;
    else if (load) busy <= 1'b1;
    else if (kill) busy <= 1'b0;
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [TAG_W-1:0] tag_q;
    assign wake_hit[s] = cmp_v && (cmp_tag < LIM) && (cmp_tag == tag_q);
    assign tags[s*TAG_W +: TAG_W] = tag_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q    <= '0;
        rdy_q[s] <= 1'b0;
      end else if (load) begin
        tag_q    <= load_tags[s*TAG_W +: TAG_W];
        rdy_q[s] <= load_rdy[s];
      end else if (wake_hit[s]) begin
        rdy_q[s] <= 1'b1;
      end
    end
  end

  assign waiting = busy ? ~rdy_q : '0;
  assign all_rdy = busy && (&rdy_q);
endmodule

// File: rtl/psb_wakeup.sv
module psb_wakeup #(
  parameter int NPREG = psb_pkg::DEF_NPREG,
  parameter int NENT  = psb_pkg::DEF_NENT,
  parameter int NSRC  = psb_pkg::DEF_NSRC,
  localparam int TAG_W  = psb_pkg::tag_width(NPREG),
  localparam int SLOT_W = psb_pkg::slot_width(NENT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_valid,
  input  logic [TAG_W-1:0]      alloc_preg,
  input  logic                  cmp_valid,
  input  logic [TAG_W-1:0]      cmp_preg,
  input  logic                  ins_valid,
  input  logic [SLOT_W-1:0]     ins_slot,
  input  logic [NSRC*TAG_W-1:0] ins_src,
  input  logic [NSRC-1:0]       ins_pre_rdy,
  input  logic [NENT-1:0]       squash_mask,
  output logic [NENT-1:0]       issue_ready,
  output logic [NENT-1:0]       slot_busy,
  output logic [NPREG-1:0]      preg_ready,
  output logic                  reuse_err
);
  localparam logic [TAG_W-1:0] LIM = TAG_W'(NPREG);

  // named internal events
  logic              alloc_tracked;
  logic              cmp_tracked;
  logic [NENT-1:0]   load_vec;
  logic [NENT-1:0]   kill_vec;
  logic [NPREG-1:0]  sb_nxt;
  logic [NSRC-1:0]   ins_rdy;
  logic [NENT-1:0]   conflict_vec;
  logic              conflict_any;

  assign alloc_tracked = alloc_valid && (alloc_preg < LIM);
  assign cmp_tracked   = cmp_valid && (cmp_preg < LIM);
  assign load_vec      = ins_valid ? (NENT'(1) << ins_slot) : '0;
  assign kill_vec      = squash_mask;

  psb_sb_bits #(.NPREG(NPREG), .TAG_W(TAG_W)) u_bits (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc_v  (alloc_tracked),
    .alloc_tag(alloc_preg),
    .cmp_v    (cmp_tracked),
    .cmp_tag  (cmp_preg),
    .bits_q   (preg_ready),
    .bits_nxt (sb_nxt)
  );

  // insertion sees this cycle's allocation and completion
  psb_insert_check #(.NPREG(NPREG), .NSRC(NSRC), .TAG_W(TAG_W)) u_chk_in (
    .src_tags(ins_src),
    .pre_rdy (ins_pre_rdy),
    .sb_view (sb_nxt),
    .src_rdy (ins_rdy)
  );

  for (genvar e = 0; e < NENT; e++) begin : g_slot
    logic [NSRC-1:0]       wait_s;
    logic [NSRC*TAG_W-1:0] tag_s;
    logic [NSRC-1:0]       clash_s;

    psb_slot #(.NPREG(NPREG), .NSRC(NSRC), .TAG_W(TAG_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .kill     (kill_vec[e]),
      .load     (load_vec[e]),
      .load_tags(ins_src),
      .load_rdy (ins_rdy),
      .cmp_v    (cmp_tracked),
      .cmp_tag  (cmp_preg),
      .busy     (slot_busy[e]),
      .waiting  (wait_s),
      .tags     (tag_s),
      .all_rdy  (issue_ready[e])
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_clash
      assign clash_s[s] = wait_s[s] && (tag_s[s*TAG_W +: TAG_W] == alloc_preg);
    end

    assign conflict_vec[e] = (|clash_s) && !kill_vec[e] && !load_vec[e];
  end

  assign conflict_any = alloc_tracked && (|conflict_vec) &&
                        !(cmp_tracked && (cmp_preg == alloc_preg));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reuse_err <= 1'b0;
    else        reuse_err <= conflict_any;
  end
endmodule

// File: rtl/psb_wakeup_chk.sv
module psb_wakeup_chk #(
  parameter int NPREG = 32,
  parameter int NENT  = 8,
  parameter int NSRC  = 2,
  localparam int TAG_W  = psb_pkg::tag_width(NPREG),
  localparam int IDX_W  = TAG_W - 1,
  localparam int SLOT_W = psb_pkg::slot_width(NENT)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_valid,
  input logic [TAG_W-1:0]  alloc_preg,
  input logic              cmp_valid,
  input logic [TAG_W-1:0]  cmp_preg,
  input logic              ins_valid,
  input logic [SLOT_W-1:0] ins_slot,
  input logic [NENT-1:0]   kill_vec,
  input logic [NENT-1:0]   load_vec,
  input logic [NENT-1:0]   issue_ready,
  input logic [NENT-1:0]   slot_busy,
  input logic [NPREG-1:0]  preg_ready,
  input logic              reuse_err
);
  localparam logic [TAG_W-1:0] LIM = TAG_W'(NPREG);

  logic [NENT-1:0] drop_vec;
  logic [NENT-1:0] keep_rdy;
  assign drop_vec = kill_vec & ~load_vec;
  assign keep_rdy = issue_ready & ~kill_vec & ~load_vec;

  // R2
  alloc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_preg < LIM) |=> !preg_ready[$past(alloc_preg[IDX_W-1:0])]);

  // R3
  cmp_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_preg < LIM && !(alloc_valid && alloc_preg == cmp_preg))
      |=> preg_ready[$past(cmp_preg[IDX_W-1:0])]);

  // R5
  untracked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!alloc_valid || alloc_preg >= LIM) && (!cmp_valid || cmp_preg >= LIM))
      |=> $stable(preg_ready));

  // R9
  squash_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|drop_vec) |=> ((slot_busy & $past(drop_vec)) == '0));

  // R6
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|keep_rdy) |=> (($past(keep_rdy) & ~issue_ready) == '0));

  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reuse_err |-> $past(alloc_valid && alloc_preg < LIM));
endmodule

bind psb_wakeup psb_wakeup_chk #(.NPREG(NPREG), .NENT(NENT), .NSRC(NSRC)) u_psb_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .alloc_valid(alloc_valid),
  .alloc_preg (alloc_preg),
  .cmp_valid  (cmp_valid),
  .cmp_preg   (cmp_preg),
  .ins_valid  (ins_valid),
  .ins_slot   (ins_slot),
  .kill_vec   (kill_vec),
  .load_vec   (load_vec),
  .issue_ready(issue_ready),
  .slot_busy  (slot_busy),
  .preg_ready (preg_ready),
  .reuse_err  (reuse_err)
);

// File: tb/psb_wakeup_bench.sv
`timescale 1ns/1ps
module psb_wakeup_bench;
  localparam int NPREG = 32;
  localparam int NENT  = 8;
  localparam int NSRC  = 2;
  localparam int TAG_W = 6;
  localparam int SLOT_W = 3;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  alloc_valid;
  logic [TAG_W-1:0]      alloc_preg;
  logic                  cmp_valid;
  logic [TAG_W-1:0]      cmp_preg;
  logic                  ins_valid;
  logic [SLOT_W-1:0]     ins_slot;
  logic [NSRC*TAG_W-1:0] ins_src;
  logic [NSRC-1:0]       ins_pre_rdy;
  logic [NENT-1:0]       squash_mask;
  logic [NENT-1:0]       issue_ready;
  logic [NENT-1:0]       slot_busy;
  logic [NPREG-1:0]      preg_ready;
  logic                  reuse_err;

  always #2 clk = ~clk;

  psb_wakeup #(.NPREG(NPREG), .NENT(NENT), .NSRC(NSRC)) u_psb_wakeup (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_preg(alloc_preg),
    .cmp_valid(cmp_valid), .cmp_preg(cmp_preg),
    .ins_valid(ins_valid), .ins_slot(ins_slot),
    .ins_src(ins_src), .ins_pre_rdy(ins_pre_rdy),
    .squash_mask(squash_mask),
    .issue_ready(issue_ready), .slot_busy(slot_busy),
    .preg_ready(preg_ready), .reuse_err(reuse_err)
  );

  typedef struct {
    string       req;
    int          sel;   // 0 ready, 1 busy, 2 scoreboard, 3 error
    logic [31:0] val;
  } exp_t;

  exp_t exp_q[$];
  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [31:0] m_sb;

  function automatic logic [31:0] observe(input int sel);
    case (sel)
      0: return 32'(issue_ready);
      1: return 32'(slot_busy);
      2: return preg_ready;
      default: return 32'(reuse_err);
    endcase
  endfunction

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      logic [31:0] act;
      e = exp_q.pop_front();
      act = observe(e.sel);
      total++;
      if (act !== e.val) begin
        bad++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", e.req, e.sel, act, e.val);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic clr();
    alloc_valid = 0; alloc_preg = '0;
    cmp_valid = 0;   cmp_preg = '0;
    ins_valid = 0;   ins_slot = '0; ins_src = '0; ins_pre_rdy = '0;
    squash_mask = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    clr();
  endtask

  task automatic push(input string r, input int sel, input logic [31:0] v);
    exp_t e;
    e.req = r; e.sel = sel; e.val = v;
    exp_q.push_back(e);
  endtask

  task automatic slots(input string r, input logic [7:0] busy, input logic [7:0] rdy);
    push(r, 1, 32'(busy));
    push(r, 0, 32'(rdy));
  endtask

  task automatic do_alloc(input int t);
    alloc_valid = 1; alloc_preg = TAG_W'(t);
  endtask

  task automatic do_cmp(input int t);
    cmp_valid = 1; cmp_preg = TAG_W'(t);
  endtask

  task automatic do_ins(input int slot, input int a, input int b, input logic [1:0] pre);
    ins_valid = 1; ins_slot = SLOT_W'(slot);
    ins_src = {TAG_W'(b), TAG_W'(a)};
    ins_pre_rdy = pre;
  endtask

  initial begin
    clr();
    m_sb = '1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R1 reset state
    push("R1", 2, m_sb); slots("R1", 8'h00, 8'h00); push("R1", 3, 0);

    // R2 producers clear bits
    do_alloc(5); tick(); m_sb[5] = 0; push("R2", 2, m_sb);
    do_alloc(7); tick(); m_sb[7] = 0; push("R2", 2, m_sb);

    // R4 insertion checks
    do_ins(0, 5, 7, 2'b00); tick(); slots("R4", 8'h01, 8'h00);
    do_ins(1, 3, 5, 2'b00); tick(); slots("R4", 8'h03, 8'h00);
    do_ins(2, 5, 9, 2'b01); tick(); slots("R4", 8'h07, 8'h04);

    // R5 untracked tags
    do_ins(3, 40, 63, 2'b00); tick(); slots("R5", 8'h0F, 8'h0C);
    do_alloc(40); tick(); push("R5", 2, m_sb);
    do_cmp(40); tick(); push("R5", 2, m_sb); slots("R5", 8'h0F, 8'h0C);

    // R10 reuse with live waiters on 5
    do_alloc(5); tick(); push("R10", 3, 1); push("R10", 2, m_sb);
    tick(); push("R10", 3, 0);

    // R6 / R8 wake on 5: slot1 ready, slot0 still waits on 7
    do_cmp(5); tick(); m_sb[5] = 1;
    push("R6", 2, m_sb); slots("R8", 8'h0F, 8'h0E);

    // R7 completion and insertion together
    do_cmp(7); do_ins(4, 7, 7, 2'b00); tick(); m_sb[7] = 1;
    slots("R7", 8'h1F, 8'h1F); push("R7", 2, m_sb);

    // R11 allocation and insertion together
    do_alloc(12); do_ins(5, 12, 3, 2'b00); tick(); m_sb[12] = 0;
    slots("R11", 8'h3F, 8'h1F); push("R11", 2, m_sb);

    // R9 squash, then no revival
    squash_mask = 8'h20; tick(); slots("R9", 8'h1F, 8'h1F);
    do_alloc(12); tick(); push("R10", 3, 0);
    do_cmp(12); tick(); m_sb[12] = 1; slots("R9", 8'h1F, 8'h1F);

    // R3 allocation wins over completion
    do_alloc(20); do_cmp(20); tick(); m_sb[20] = 0; push("R3", 2, m_sb);
    do_cmp(20); tick(); m_sb[20] = 1; push("R3", 2, m_sb);

    // R6 one broadcast wakes two slots
    do_alloc(22); tick(); m_sb[22] = 0; push("R2", 2, m_sb);
    do_ins(6, 22, 22, 2'b00); tick(); slots("R6", 8'h5F, 8'h1F);
    do_ins(7, 22, 3, 2'b00); tick(); slots("R6", 8'hDF, 8'h1F);
    do_cmp(22); tick(); m_sb[22] = 1; slots("R6", 8'hDF, 8'hDF);

    // R9 squash and insertion on one slot: insertion wins
    do_alloc(25); tick(); m_sb[25] = 0;
    squash_mask = 8'h01; do_ins(0, 25, 3, 2'b00); tick();
    slots("R9", 8'hDF, 8'hDE);
    squash_mask = 8'hFF; tick(); slots("R9", 8'h00, 8'h00);

    tick();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule